// File: doc/BRIEF.md
# Hybrid Coherence Directory Entry

This block holds the sharer record of a single cache line at its home memory cache and decides which coherence action each write or eviction of that line needs. A copy is named by the source identifier of the first-level cache that holds it and by a type bit: 0 for a data copy and 1 for an instruction copy. One processor that holds the line in both of its caches therefore owns two separate entries. Events arrive on `ev_valid` with `ev_op`, using these encodings: 00 registers a copy, 01 is a cleanup that removes a copy, 10 is a write, and 11 is an eviction.

The entry is a three-state machine:

- **EMPTY** (mode 00) holds no copies.
- **LIST** (mode 01) holds an exact list of up to `THRESH` copies, each in a slot.
- **COUNT** (mode 10) holds only a number of copies.

The named transitions are:

- **first_reg**: EMPTY to LIST.
- **overflow**: LIST to COUNT, taken on a registration that would exceed the list.
- **drain**: LIST or COUNT to EMPTY, taken when a cleanup removes the last copy.
- **flush**: LIST or COUNT to EMPTY, taken on an eviction, or on a write in COUNT.

Every other event stays in the current state.

One cycle after each event, a registered action appears on the `act_*` outputs, and the new state is visible on `mode` and `copies`. Action kinds are encoded as follows:

- 00: none.
- 01: multicast update.
- 10: multicast invalidate.
- 11: broadcast invalidate.

For a multicast action, `act_mask` marks the targeted slots, and `act_src`/`act_instr` carry those slots' identifiers (slot i occupies bits i*SRC_W upward). For a broadcast action, `act_count` carries the number of responses to expect.

Top module: `coh_dir_entry`

## Requirements
- R1: After reset, `mode` is 00, `copies` is 0, `act_valid` is 0 and `cleanup_err` is 0.
- R2: Registering a (source, type) pair that is not present stores it in the lowest-numbered free slot, increments `copies` and leaves mode 01. The data and instruction copies of one source occupy separate slots.
- R3: Registering a pair that is already present in LIST mode changes neither the slots nor `copies`.
- R4: Registering a new pair while LIST holds `THRESH` entries discards the list and enters mode 10 with `copies` = `THRESH`+1. Each further registration in mode 10 increments `copies`.
- R5: A write in mode 01 produces kind 01, with `act_mask` set for every occupied slot except the data copy of the writing source, and `act_count` equal to the number of mask bits. If no slot is targeted, the kind is 00. The list is kept.
- R6: An eviction in mode 01 produces kind 10 with every occupied slot in `act_mask` (a copy of the evicting source included) and `act_count` = `copies`. Afterwards the mode is 00.
- R7: A write or eviction in mode 10 produces kind 11 with `act_count` equal to the stored `copies` and a zero mask. Afterwards the mode is 00 and `copies` is 0.
- R8: A cleanup in mode 01 that matches a slot's source and type frees that slot and decrements `copies`. Freeing the last slot returns the mode to 00.
- R9: A cleanup in mode 10 decrements `copies`. Reaching zero returns the mode to 00.
- R10: A cleanup in mode 00, or one that matches no slot in mode 01, leaves the state unchanged and sets `cleanup_err`, which stays at 1 until reset.
- R11: `act_valid` is 1 in exactly the one cycle after each event. A write or eviction in mode 00 reports kind 00 with `act_count` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_op | input | 2 | 00 register, 01 cleanup, 10 write, 11 evict |
| ev_src | input | SRC_W | Source identifier of the cache or writer |
| ev_instr | input | 1 | Copy type: 0 data, 1 instruction (ignored on write/evict) |
| act_valid | output | 1 | Action result valid |
| act_kind | output | 2 | 00 none, 01 mcast update, 10 mcast inval, 11 broadcast inval |
| act_mask | output | THRESH | Targeted list slots |
| act_src | output | THRESH*SRC_W | Source identifier of each targeted slot |
| act_instr | output | THRESH | Type bit of each targeted slot |
| act_count | output | CNT_W | Expected response count |
| mode | output | 2 | 00 EMPTY, 01 LIST, 10 COUNT |
| copies | output | CNT_W | Number of recorded copies |
| cleanup_err | output | 1 | Sticky unmatched-cleanup flag |

## Verification
A corrupted slot or counter stays hidden until the line is next written or evicted: the mask, the identifiers and `act_count` of that one action expose it. `copies` and `mode` reveal a wrong count or a missed mode switch in the very next cycle. A lost slot therefore shows up either as a wrong `copies` value one cycle after the event, or as a missing mask bit at the first write. The bench drives every list occupancy from one to beyond the threshold and reads the next action after each occupancy. A stale list left after a flush would show up as a nonzero mode or count right after the flushing event.

// File: rtl/coh_dir_pkg.sv
`timescale 1ns/1ps
package coh_dir_pkg;
    typedef enum logic [1:0] {
        OP_REG   = 2'b00,
        OP_CLEAN = 2'b01,
        OP_WRITE = 2'b10,
        OP_EVICT = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_MUPD = 2'b01,
        ACT_MINV = 2'b10,
        ACT_BINV = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_LIST  = 2'b01,
        ST_COUNT = 2'b10
    } mode_e;
endpackage

// File: rtl/coh_dir_match.sv
`timescale 1ns/1ps
// Per-slot comparison of a (source, type) key against the occupied slots.
module coh_dir_match #(
    parameter int NSLOT = 4,
    parameter int SRC_W = 4
) (
    input  logic [NSLOT-1:0]            slot_vld,
    input  logic [NSLOT-1:0][SRC_W-1:0] slot_src,
    input  logic [NSLOT-1:0]            slot_ins,
    input  logic [SRC_W-1:0]            key_src,
    input  logic                        key_ins,
    output logic [NSLOT-1:0]            hit
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        assign hit[g] = slot_vld[g] && (slot_src[g] == key_src) && (slot_ins[g] == key_ins);
    end
endmodule

// File: rtl/coh_dir_pick.sv
`timescale 1ns/1ps
// Lowest-index one-hot selection among requesting bits.
module coh_dir_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    always_comb begin
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && grant == '0) grant[i] = 1'b1;
        end
    end
endmodule

// File: rtl/coh_dir_entry.sv
`timescale 1ns/1ps
module coh_dir_entry
    import coh_dir_pkg::*;
#(
    parameter int THRESH = 4,
    parameter int SRC_W  = 4,
    parameter int CNT_W  = $clog2(2 * (1 << SRC_W) + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ev_valid,
    input  logic [1:0]              ev_op,
    input  logic [SRC_W-1:0]        ev_src,
    input  logic                    ev_instr,
    output logic                    act_valid,
    output logic [1:0]              act_kind,
    output logic [THRESH-1:0]       act_mask,
    output logic [THRESH*SRC_W-1:0] act_src,
    output logic [THRESH-1:0]       act_instr,
    output logic [CNT_W-1:0]        act_count,
    output logic [1:0]              mode,
    output logic [CNT_W-1:0]        copies,
    output logic                    cleanup_err
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] LIST_CAP = CNT_W'(THRESH);
    localparam logic [CNT_W-1:0] OVF_CNT  = CNT_W'(THRESH + 1);

    // Entry state
    mode_e                         st_q, st_d;
    logic [THRESH-1:0]             vld_q, vld_d;
    logic [THRESH-1:0][SRC_W-1:0]  src_q, src_d;
    logic [THRESH-1:0]             ins_q, ins_d;
    logic [CNT_W-1:0]              cnt_q, cnt_d;
    logic                          err_q, err_d;

    // Action next values
    act_e                          kind_d;
    logic [THRESH-1:0]             mask_d;
    logic [CNT_W-1:0]              acnt_d;
    logic [THRESH-1:0][SRC_W-1:0]  asrc_d, asrc_q;
    logic [THRESH-1:0]             ains_d;

    op_e               op;
    logic [THRESH-1:0] hit;
    logic [THRESH-1:0] free_slot;
    logic              key_ins;

    assign op      = op_e'(ev_op);
    // A write is matched against the writer's data copy only.
    assign key_ins = (op == OP_WRITE) ? 1'b0 : ev_instr;

    coh_dir_match #(.NSLOT(THRESH), .SRC_W(SRC_W)) u_match (
        .slot_vld (vld_q),
        .slot_src (src_q),
        .slot_ins (ins_q),
        .key_src  (ev_src),
        .key_ins  (key_ins),
        .hit      (hit)
    );

    coh_dir_pick #(.N(THRESH)) u_pick (
        .req   (~vld_q),
        .grant (free_slot)
    );

    function automatic logic [CNT_W-1:0] popcnt(input logic [THRESH-1:0] v);
        logic [CNT_W-1:0] s;
        s = '0;
        for (int i = 0; i < THRESH; i++) s = s + CNT_W'(v[i]);
        return s;
    endfunction

    // Next-state and action decision
    always_comb begin
        st_d   = st_q;
        vld_d  = vld_q;
        src_d  = src_q;
        ins_d  = ins_q;
        cnt_d  = cnt_q;
        err_d  = err_q;
        kind_d = ACT_NONE;
        mask_d = '0;
        acnt_d = '0;
        if (ev_valid) begin
            unique case (op)
                OP_REG: begin
                    if (st_q == ST_COUNT) begin
                        if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
                    end else if (hit == '0) begin
                        if (cnt_q < LIST_CAP) begin          // first_reg / stay in LIST
                            vld_d = vld_q | free_slot;
                            for (int i = 0; i < THRESH; i++) begin
                                if (free_slot[i]) begin
                                    src_d[i] = ev_src;
                                    ins_d[i] = ev_instr;
                                end
                            end
                            cnt_d = cnt_q + CNT_ONE;
                            st_d  = ST_LIST;
                        end else begin                       // overflow
                            vld_d = '0;
                            cnt_d = OVF_CNT;
                            st_d  = ST_COUNT;
                        end
                    end
                end
                OP_CLEAN: begin
                    if (st_q == ST_COUNT) begin
                        cnt_d = cnt_q - CNT_ONE;
                        if (cnt_q == CNT_ONE) st_d = ST_EMPTY;   // drain
                    end else if (hit != '0) begin
                        vld_d = vld_q & ~hit;
                        cnt_d = cnt_q - CNT_ONE;
                        if (cnt_q == CNT_ONE) st_d = ST_EMPTY;   // drain
                    end else begin
                        err_d = 1'b1;
                    end
                end
                OP_WRITE, OP_EVICT: begin
                    if (st_q == ST_COUNT) begin                  // flush via broadcast
                        kind_d = ACT_BINV;
                        acnt_d = cnt_q;
                        cnt_d  = '0;
                        st_d   = ST_EMPTY;
                    end else if (op == OP_WRITE) begin
                        mask_d = vld_q & ~hit;
                        kind_d = (mask_d != '0) ? ACT_MUPD : ACT_NONE;
                        acnt_d = popcnt(mask_d);
                    end else begin                               // flush via multicast
                        mask_d = vld_q;
                        kind_d = (vld_q != '0) ? ACT_MINV : ACT_NONE;
                        acnt_d = cnt_q;
                        vld_d  = '0;
                        cnt_d  = '0;
                        st_d   = ST_EMPTY;
                    end
                end
            endcase
        end
        for (int i = 0; i < THRESH; i++) begin
            asrc_d[i] = mask_d[i] ? src_q[i] : '0;
            ains_d[i] = mask_d[i] & ins_q[i];
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_EMPTY;
            vld_q <= '0;
            src_q <= '0;
            ins_q <= '0;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            vld_q <= vld_d;
            src_q <= src_d;
            ins_q <= ins_d;
            cnt_q <= cnt_d;
            err_q <= err_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_valid <= 1'b0;
            act_kind  <= ACT_NONE;
            act_mask  <= '0;
            asrc_q    <= '0;
            act_instr <= '0;
            act_count <= '0;
        end else begin
            act_valid <= ev_valid;
            act_kind  <= kind_d;
            act_mask  <= mask_d;
            asrc_q    <= asrc_d;
            act_instr <= ains_d;
            act_count <= acnt_d;
        end
    end

    assign act_src     = asrc_q;
    assign mode        = st_q;
    assign copies      = cnt_q;
    assign cleanup_err = err_q;

    // R1: empty state carries no copies
    p_empty_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_EMPTY |-> (cnt_q == '0 && vld_q == '0));
    // R2: list count matches occupied slots and stays within capacity
    p_list_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_LIST |-> ($countones(vld_q) == int'(cnt_q) && cnt_q <= LIST_CAP && cnt_q != '0));
    // R4: count mode holds no slot contents
    p_count_noslot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_COUNT |-> (vld_q == '0 && cnt_q != '0));
    // R7: write or eviction in count mode leads to a broadcast
    p_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_op[1] && st_q == ST_COUNT) |=> (act_kind == ACT_BINV && st_q == ST_EMPTY));
    // R5: multicast targets only slots that were occupied
    p_mask_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> ((act_mask & ~$past(vld_q)) == '0));
    // R10: the error flag never clears outside reset
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    // R11: one action per event, in the next cycle
    p_act_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> act_valid);
    p_act_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> !act_valid);
endmodule

// File: tb/coh_dir_entry_tb.sv
`timescale 1ns/1ps
module coh_dir_entry_tb;
    localparam int THRESH = 4;
    localparam int SRC_W  = 4;
    localparam int CNT_W  = $clog2(2 * (1 << SRC_W) + 1);

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    ev_valid = 1'b0;
    logic [1:0]              ev_op = 2'b00;
    logic [SRC_W-1:0]        ev_src = '0;
    logic                    ev_instr = 1'b0;
    logic                    act_valid;
    logic [1:0]              act_kind;
    logic [THRESH-1:0]       act_mask;
    logic [THRESH*SRC_W-1:0] act_src;
    logic [THRESH-1:0]       act_instr;
    logic [CNT_W-1:0]        act_count;
    logic [1:0]              mode;
    logic [CNT_W-1:0]        copies;
    logic                    cleanup_err;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    coh_dir_entry #(.THRESH(THRESH), .SRC_W(SRC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_op(ev_op),
        .ev_src(ev_src), .ev_instr(ev_instr), .act_valid(act_valid),
        .act_kind(act_kind), .act_mask(act_mask), .act_src(act_src),
        .act_instr(act_instr), .act_count(act_count), .mode(mode),
        .copies(copies), .cleanup_err(cleanup_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one event; returns at the negedge where its action is visible.
    task automatic ev(input logic [1:0] op, input int src, input logic ins);
        @(negedge clk);
        ev_valid = 1'b1; ev_op = op; ev_src = SRC_W'(src); ev_instr = ins;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 mode", int'(mode), 0);
        chk("R1 copies", int'(copies), 0);
        chk("R1 act_valid", int'(act_valid), 0);
        chk("R1 err", int'(cleanup_err), 0);

        // Sweep occupancy 1..7: copy i is (src i/2, type i%2).
        for (int k = 1; k <= 7; k++) begin
            for (int i = 0; i < k; i++) ev(2'b00, i / 2, 1'(i % 2));
            chk("R2/R4 mode", int'(mode), (k <= THRESH) ? 1 : 2);
            chk("R2/R4 copies", int'(copies), k);
            ev(2'b10, 0, 1'b0);
            chk("R11 act_valid", int'(act_valid), 1);
            if (k <= THRESH) begin
                chk("R5 kind", int'(act_kind), (k > 1) ? 1 : 0);
                chk("R5 mask", int'(act_mask), ((1 << k) - 1) & ~1);
                chk("R5 count", int'(act_count), k - 1);
                if (k == THRESH) begin
                    chk("R5 src", int'(act_src), 32'h1100);
                    chk("R5 instr", int'(act_instr), 4'b1010);
                end
                chk("R5 kept", int'(copies), k);
                ev(2'b11, 0, 1'b0);
                chk("R6 kind", int'(act_kind), 2);
                chk("R6 mask", int'(act_mask), (1 << k) - 1);
                chk("R6 count", int'(act_count), k);
                chk("R6 mode", int'(mode), 0);
            end else begin
                chk("R7 kind", int'(act_kind), 3);
                chk("R7 count", int'(act_count), k);
                chk("R7 mask", int'(act_mask), 0);
                chk("R7 mode", int'(mode), 0);
                chk("R7 copies", int'(copies), 0);
            end
            @(negedge clk);
            chk("R11 pulse", int'(act_valid), 0);
        end

        // Empty-state write and evict
        ev(2'b10, 3, 1'b0);
        chk("R11 none", int'(act_kind), 0);
        chk("R11 zero count", int'(act_count), 0);
        ev(2'b11, 3, 1'b0);
        chk("R11 none evict", int'(act_kind), 0);

        // Duplicates
        ev(2'b00, 5, 1'b1);
        ev(2'b00, 5, 1'b1);
        chk("R3 dup", int'(copies), 1);
        ev(2'b00, 5, 1'b0);
        chk("R2 both types", int'(copies), 2);
        ev(2'b11, 5, 1'b0);
        chk("R6 dup mask", int'(act_mask), 3);

        // Lowest free slot reuse
        ev(2'b00, 1, 1'b0);
        ev(2'b00, 2, 1'b0);
        ev(2'b00, 3, 1'b0);
        ev(2'b01, 2, 1'b0);
        chk("R8 remove", int'(copies), 2);
        ev(2'b00, 4, 1'b1);
        ev(2'b10, 9, 1'b0);
        chk("R2 reuse mask", int'(act_mask), 7);
        chk("R2 reuse src", int'(act_src), 32'h341);
        chk("R2 reuse instr", int'(act_instr), 2);
        chk("R5 outsider count", int'(act_count), 3);

        // Unmatched cleanup (type differs)
        ev(2'b01, 1, 1'b1);
        chk("R10 err", int'(cleanup_err), 1);
        chk("R10 copies", int'(copies), 3);
        chk("R10 mode", int'(mode), 1);
        ev(2'b01, 1, 1'b0);
        ev(2'b01, 4, 1'b1);
        chk("R8 mode", int'(mode), 1);
        ev(2'b01, 3, 1'b0);
        chk("R8 drain", int'(mode), 0);
        chk("R10 sticky", int'(cleanup_err), 1);
        do_reset();
        chk("R1 err clear", int'(cleanup_err), 0);
        ev(2'b01, 7, 1'b0);
        chk("R10 empty err", int'(cleanup_err), 1);
        chk("R10 empty copies", int'(copies), 0);
        do_reset();

        // Count mode registration and cleanup
        for (int i = 0; i < 6; i++) ev(2'b00, i, 1'b0);
        chk("R4 count inc", int'(copies), 6);
        for (int i = 6; i > 0; i--) begin
            chk("R9 mode", int'(mode), 2);
            ev(2'b01, 12, 1'b1);
            chk("R9 dec", int'(copies), i - 1);
        end
        chk("R9 drain", int'(mode), 0);
        chk("R9 no err", int'(cleanup_err), 0);

        // Eviction in count mode
        for (int i = 0; i < 5; i++) ev(2'b00, i, 1'b1);
        ev(2'b11, 0, 1'b0);
        chk("R7 evict kind", int'(act_kind), 3);
        chk("R7 evict count", int'(act_count), 5);
        chk("R7 evict mode", int'(mode), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule